// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block is a synthesizable model of a small serial EEPROM that answers as a target on a four-wire SPI link. It holds a byte-wide array with 128 entries, arranged as 16 aligned pages of 8 bytes. It also holds a status byte with a busy flag, a write-enable latch and two stored protect bits. It decodes one-byte opcodes that let a host set or clear the latch, read or write the status byte, read the array from any address, and program data into one page.

The serial pins are sampled by the block's own system clock, so they must be synchronous to it. Each serial clock phase must last at least three system clock cycles. Page data is first collected in a staging buffer and is written into the array when chip select is released. A counter then keeps the busy flag set for a programmable number of system clocks. While busy is set, only the status read is honoured.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads the erased value 0xFF.
- R2: The link runs in mode 0. MOSI is sampled on rising SCK, MISO changes after falling SCK, and bits move most significant first. Reply bits fill the byte that follows the opcode (status) or the address byte (data).
- R3: Status layout: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect bits, and bits 7:4 read 0. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R4: Opcode 0x05 returns the status byte in every byte that follows it while chip select stays low. Each byte is refreshed with the live busy value.
- R5: Opcode 0x01 followed by one byte copies bits 3:2 of that byte into the protect bits and clears the latch, but only if the latch is set. With the latch clear it changes nothing.
- R6: Opcode 0x03 followed by an address byte returns consecutive array bytes for as long as chip select stays low. The address wraps from 127 to 0, and address bit 7 is ignored.
- R7: Opcode 0x02 issued with the latch clear is ignored, and the array does not change.
- R8: Opcode 0x02 with the latch set takes an address byte, whose bit 7 is ignored, then data bytes. Each data byte goes to the next position inside the aligned 8-byte page and wraps to the start of that page. Page positions that were not sent keep their old contents.
- R9: A write that sent at least one complete data byte is committed when chip select rises. At that point the latch clears and busy stays set for WRITE_CYCLES system clocks. A write that sent no complete data byte commits nothing, does not set busy, and leaves the latch set.
- R10: While busy is set, every opcode other than 0x05 is ignored. A data read during this time returns 0x00, and 0x06 does not set the latch.
- R11: Unknown opcodes are ignored. An incomplete final byte at chip-select release is discarded.
- R12: MISO is held low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial pins are sampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench builds the block with WRITE_CYCLES set to 300 and keeps the default 7-bit address with 8-byte pages. With an 8-clock serial bit time, the whole busy window fits inside about five status bytes. A single held-low status poll therefore sees busy go from set to clear, and commands can be issued in the middle of the window. The default geometry keeps both the page-wrap and array-wrap edges reachable with short bursts.

// File: rtl/spi_ee_pkg.sv
// Shared constants and types for the serial EEPROM model.
package spi_ee_pkg;
    // Command opcodes received as the first byte of a selection
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // Command phase of the current selection
    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR_RD,
        PH_DATA_RD,
        PH_STAT_RD,
        PH_STAT_WR,
        PH_ADDR_WR,
        PH_DATA_WR,
        PH_DROP
    } phase_t;
endpackage

// File: rtl/spi_ee_link.sv
// Serial link front end: oversamples SCK/CS_N with the system clock, shifts
// in MOSI on rising SCK (mode 0, MSB first) and presents one bit of tx_byte
// on MISO after each falling SCK. Assumes the serial pins are synchronous to
// clk and each SCK phase lasts at least three clk cycles.
module spi_ee_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       sel_end
);
    logic       sck_q;
    logic       cs_q;
    logic [6:0] shreg;
    logic [2:0] bit_cnt;
    logic       miso_q;
    logic       sck_rise;
    logic       sck_fall;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign miso     = miso_q;

    // Edge tracking, bit shifting, byte framing and MISO update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            cs_q       <= 1'b1;
            shreg      <= '0;
            bit_cnt    <= '0;
            miso_q     <= 1'b0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
            sel_end    <= 1'b0;
        end else begin
            sck_q      <= sck;
            cs_q       <= cs_n;
            sel_end    <= ~cs_q & cs_n;
            byte_valid <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                miso_q  <= 1'b0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {shreg, mosi};
                end
            end else if (sck_fall) begin
                miso_q <= tx_byte[~bit_cnt];
            end
        end
    end
endmodule

// File: rtl/spi_ee_busy.sv
// Write-cycle timer: loads WRITE_CYCLES on a commit pulse and counts down;
// busy is high while the count is non-zero.
module spi_ee_busy #(
    parameter int WRITE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);

    // Countdown of the programming window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(WRITE_CYCLES);
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_ee_array.sv
// Byte array storage: asynchronous read port, page-wide masked write port.
// Resets every byte to the erased value.
module spi_ee_array #(
    parameter int         ADDR_W = 7,
    parameter int         PAGE_W = 3,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [7:0]                           rd_data,
    input  logic                                 wr_en,
    input  logic [ADDR_W-PAGE_W-1:0]             wr_page,
    input  logic [(1<<PAGE_W)-1:0]               wr_mask,
    input  logic [(1<<PAGE_W)-1:0][7:0]          wr_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int NPAGES     = DEPTH / PAGE_BYTES;
    localparam int PG_W       = ADDR_W - PAGE_W;

    logic [7:0]        mem [DEPTH];
    logic [NPAGES-1:0] page_hit;

    // One page-select decode per page
    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        assign page_hit[p] = wr_en && (wr_page == PG_W'(p));
    end

    assign rd_data = mem[rd_addr];

    // Masked update of the selected page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (page_hit[i / PAGE_BYTES] && wr_mask[i % PAGE_BYTES])
                    mem[i] <= wr_data[i % PAGE_BYTES];
            end
        end
    end
endmodule

// File: rtl/spi_ee_ctrl.sv
// Command sequencer: decodes opcodes, holds the status bits, steers read
// addresses, stages page data and issues a commit on chip-select release.
// Assumes byte_valid and sel_end come from the link one cycle after the event.
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 byte_valid,
    input  logic [7:0]                           rx_byte,
    input  logic                                 sel_end,
    input  logic                                 busy,
    input  logic [7:0]                           rd_data,
    output logic [ADDR_W-1:0]                    rd_addr,
    output logic [7:0]                           tx_byte,
    output logic                                 wel,
    output logic                                 commit,
    output logic [ADDR_W-PAGE_W-1:0]             wr_page,
    output logic [(1<<PAGE_W)-1:0]               wr_mask,
    output logic [(1<<PAGE_W)-1:0][7:0]          wr_data
);
    phase_t             phase;
    logic [1:0]         bp;
    logic [ADDR_W-1:0]  rd_ptr;
    logic [PAGE_W-1:0]  wr_off;
    logic [7:0]         status;

    // Live status byte: busy at bit 0, latch at bit 1, protect at bits 3:2
    assign status  = {4'b0000, bp, wel, busy};

    // Array read address: incoming address byte, then the running pointer
    assign rd_addr = (phase == PH_ADDR_RD) ? rx_byte[ADDR_W-1:0] : rd_ptr;

    // Command phase sequencing, status updates and page staging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_OPC;
            tx_byte <= '0;
            wel     <= 1'b0;
            bp      <= '0;
            rd_ptr  <= '0;
            wr_off  <= '0;
            wr_page <= '0;
            wr_mask <= '0;
            wr_data <= '0;
            commit  <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (sel_end) begin
                if (phase == PH_DATA_WR && wr_mask != '0) begin
                    commit <= 1'b1;
                    wel    <= 1'b0;
                end
                phase   <= PH_OPC;
                tx_byte <= '0;
            end else if (byte_valid) begin
                case (phase)
                    PH_OPC: begin
                        if (busy && rx_byte != OP_RDSR) begin
                            phase <= PH_DROP;
                        end else begin
                            case (rx_byte)
                                OP_WREN: begin
                                    wel   <= 1'b1;
                                    phase <= PH_DROP;
                                end
                                OP_WRDI: begin
                                    wel   <= 1'b0;
                                    phase <= PH_DROP;
                                end
                                OP_RDSR: begin
                                    tx_byte <= status;
                                    phase   <= PH_STAT_RD;
                                end
                                OP_WRSR:  phase <= wel ? PH_STAT_WR : PH_DROP;
                                OP_READ:  phase <= PH_ADDR_RD;
                                OP_WRITE: phase <= wel ? PH_ADDR_WR : PH_DROP;
                                default:  phase <= PH_DROP;
                            endcase
                        end
                    end
                    PH_STAT_RD: tx_byte <= status;
                    PH_STAT_WR: begin
                        bp    <= rx_byte[3:2];
                        wel   <= 1'b0;
                        phase <= PH_DROP;
                    end
                    PH_ADDR_RD: begin
                        tx_byte <= rd_data;
                        rd_ptr  <= rx_byte[ADDR_W-1:0] + 1'b1;
                        phase   <= PH_DATA_RD;
                    end
                    PH_DATA_RD: begin
                        tx_byte <= rd_data;
                        rd_ptr  <= rd_ptr + 1'b1;
                    end
                    PH_ADDR_WR: begin
                        wr_page <= rx_byte[ADDR_W-1:PAGE_W];
                        wr_off  <= rx_byte[PAGE_W-1:0];
                        wr_mask <= '0;
                        phase   <= PH_DATA_WR;
                    end
                    PH_DATA_WR: begin
                        wr_data[wr_off] <= rx_byte;
                        wr_mask[wr_off] <= 1'b1;
                        wr_off          <= wr_off + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_model.sv
// Top of the serial EEPROM model: link front end, command sequencer,
// byte array and write-cycle timer. Serial pins must be synchronous to clk.
module spi_eeprom_model #(
    parameter int         ADDR_W       = 7,
    parameter int         PAGE_W       = 3,
    parameter int         WRITE_CYCLES = 1250000,
    parameter logic [7:0] ERASED       = 8'hFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;

    logic                        byte_valid;
    logic [7:0]                  rx_byte;
    logic                        sel_end;
    logic [7:0]                  tx_byte;
    logic                        busy;
    logic                        wel;
    logic [ADDR_W-1:0]           rd_addr;
    logic [7:0]                  rd_data;
    logic                        wr_en;
    logic [PG_W-1:0]             wr_page;
    logic [PAGE_BYTES-1:0]       wr_mask;
    logic [PAGE_BYTES-1:0][7:0]  wr_data;

    spi_ee_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .tx_byte    (tx_byte),
        .miso       (miso),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .sel_end    (sel_end)
    );

    spi_ee_ctrl #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .sel_end    (sel_end),
        .busy       (busy),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .tx_byte    (tx_byte),
        .wel        (wel),
        .commit     (wr_en),
        .wr_page    (wr_page),
        .wr_mask    (wr_mask),
        .wr_data    (wr_data)
    );

    spi_ee_array #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .ERASED (ERASED)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_page (wr_page),
        .wr_mask (wr_mask),
        .wr_data (wr_data)
    );

    spi_ee_busy #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_en),
        .busy  (busy)
    );
endmodule

// File: rtl/spi_ee_checker.sv
// Property checker for the serial EEPROM model, bound to its top module.
module spi_ee_checker #(
    parameter int PAGE_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_n,
    input logic                    miso,
    input logic                    wr_en,
    input logic [(1<<PAGE_W)-1:0]  wr_mask,
    input logic                    busy,
    input logic                    wel
);
    // R9: a commit never starts while a previous write cycle runs
    a_r9_commit_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);

    // R9: busy follows a commit
    a_r9_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);

    // R9: latch is clear once a write commits
    a_r9_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wel);

    // R8: a commit always carries at least one staged byte
    a_r8_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_mask != '0));

    // R10: the latch cannot be set by a command decoded during busy
    a_r10_no_latch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));

    // R12: MISO stays low while deselected
    a_r12_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);
endmodule

bind spi_eeprom_model spi_ee_checker #(.PAGE_W(PAGE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .miso    (miso),
    .wr_en   (wr_en),
    .wr_mask (wr_mask),
    .busy    (busy),
    .wel     (wel)
);

// File: tb/sim_spi_eeprom_model.sv
module sim_spi_eeprom_model;
    localparam int ADDR_W = 7;
    localparam int PAGE_W = 3;
    localparam int WCYC   = 300;
    localparam int HALF   = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    always #4 clk = ~clk;

    spi_eeprom_model #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .WRITE_CYCLES (WCYC),
        .ERASED       (8'hFF)
    ) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .mosi  (mosi),
        .miso  (miso)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [DEPTH];
    logic       m_wel;
    logic [1:0] m_bp;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[7-i];
            tick(HALF);
            rx = {rx[6:0], miso};
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    function automatic logic [7:0] exp_status(input logic busy);
        return {4'b0000, m_bp, m_wel, busy};
    endfunction

    function automatic int page_idx(input logic [7:0] a, input int k);
        logic [2:0] off;
        off = a[2:0] + 3'(k);
        return int'({a[6:3], off});
    endfunction

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, 8, r);
        desel();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic status_chk(input string req, input logic [7:0] exp);
        logic [7:0] r;
        sel();
        xfer(8'h05, 8, r);
        xfer(8'h00, 8, r);
        desel();
        check(req, r, exp);
    endtask

    task automatic read_chk(input string req, input logic [7:0] addr, input int len);
        logic [7:0] r;
        sel();
        xfer(8'h03, 8, r);
        xfer(addr, 8, r);
        for (int k = 0; k < len; k++) begin
            xfer(8'h00, 8, r);
            check(req, r, mdl[(int'(addr[6:0]) + k) % DEPTH]);
        end
        desel();
    endtask

    task automatic write_data(input logic [7:0] addr, input int len, output bit started);
        logic [7:0] r;
        logic [7:0] d;
        sel();
        xfer(8'h02, 8, r);
        xfer(addr, 8, r);
        started = m_wel && (len > 0);
        for (int k = 0; k < len; k++) begin
            d = 8'($urandom);
            xfer(d, 8, r);
            if (m_wel) mdl[page_idx(addr, k)] = d;
        end
        desel();
        if (started) m_wel = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] d1;
        bit         st;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        m_wel = 1'b0;
        m_bp  = 2'b00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset status and erased array
        status_chk("R1 reset status", 8'h00);
        read_chk("R1 erased array", 8'h00, 4);

        // R12: deselected output stays low
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R12 miso idle", miso, 0);
        end

        // R2 R3: latch set shows as 0x02 (bit order distinguishes 0x40)
        op1(8'h06);
        status_chk("R2 R3 latch set", 8'h02);
        op1(8'h04);
        status_chk("R3 latch cleared", 8'h00);

        // R7: write without latch is ignored
        write_data(8'h10, 3, st);
        read_chk("R7 array unchanged", 8'h10, 3);

        // R8 R9 R4: page-wrapping write then poll across the busy window
        op1(8'h06);
        write_data(8'h0D, 5, st);
        sel();
        xfer(8'h05, 8, r);
        xfer(8'h00, 8, r);
        check("R9 busy set latch clear", r, 8'h01);
        for (int k = 0; k < 5; k++) xfer(8'h00, 8, r);
        check("R4 status refreshed busy clear", r, 8'h00);
        desel();
        read_chk("R8 page wrap data", 8'h08, 8);
        read_chk("R6 R8 address bit7 ignored", 8'h8D, 3);

        // R10: commands ignored during busy
        op1(8'h06);
        write_data(8'h40, 1, st);
        sel();
        xfer(8'h03, 8, r);
        xfer(8'h40, 8, r);
        xfer(8'h00, 8, r);
        desel();
        check("R10 read during busy", r, 8'h00);
        sel();
        xfer(8'h06, 8, r);
        desel();
        tick(WCYC + 10);
        status_chk("R10 latch not set while busy", 8'h00);
        read_chk("R8 single byte", 8'h40, 2);

        // R6: array wrap from 127 to 0
        read_chk("R6 array wrap", 8'h7E, 4);

        // R9: write with no data byte keeps latch, no busy
        op1(8'h06);
        write_data(8'h20, 0, st);
        status_chk("R9 empty write", 8'h02);

        // R11: partial trailing byte discarded
        d1 = 8'h5A;
        sel();
        xfer(8'h02, 8, r);
        xfer(8'h20, 8, r);
        xfer(d1, 8, r);
        xfer(8'hC3, 5, r);
        desel();
        mdl[8'h20] = d1;
        m_wel = 1'b0;
        tick(WCYC + 10);
        read_chk("R11 partial byte dropped", 8'h20, 2);

        // R11: unknown opcode has no effect
        op1(8'h06);
        sel();
        xfer(8'hAB, 8, r);
        xfer(8'h00, 8, r);
        desel();
        status_chk("R11 unknown opcode", 8'h02);

        // R5: status write with and without latch
        sel();
        xfer(8'h01, 8, r);
        xfer(8'hFC, 8, r);
        desel();
        m_bp = 2'b11;
        m_wel = 1'b0;
        status_chk("R5 protect bits stored", 8'h0C);
        sel();
        xfer(8'h01, 8, r);
        xfer(8'h00, 8, r);
        desel();
        status_chk("R5 no latch no change", 8'h0C);

        // Random mix checked against the bench model
        for (int n = 0; n < 40; n++) begin
            case ($urandom % 6)
                0: op1(8'h06);
                1: op1(8'h04);
                2: status_chk("R3 R4 random status", exp_status(1'b0));
                3: begin
                    d1 = 8'($urandom);
                    sel();
                    xfer(8'h01, 8, r);
                    xfer(d1, 8, r);
                    desel();
                    if (m_wel) begin
                        m_bp = d1[3:2];
                        m_wel = 1'b0;
                    end
                end
                4: read_chk("R6 random read", 8'($urandom), 1 + int'($urandom % 10));
                default: begin
                    write_data(8'($urandom), int'($urandom % 11), st);
                    if (st) tick(WCYC + 10);
                end
            endcase
        end
        read_chk("R8 final array", 8'h00, DEPTH);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule